// File: doc/BRIEF.md
# MCU Power Mode and Clock Controller

This block decides which clocks reach a small 8-bit MCU core and its peripherals. It runs from the oscillator clock `clk_osc`. From it the block produces a divided core tick, a peripheral enable and two gated clocks. A 3-bit prescaler setting chooses the core division.

Software picks a power state with two one-cycle strobes. `idle_set` stops only the core. `pd_set` stops the core and the peripherals. Each state has its own exit rule:

- Idle ends on any enabled interrupt, or on a supervisor reset.
- Power-down ends only on an external, low-voltage or debug reset.

The watchdog is clocked from the divided core tick, so it is frozen whenever the core is. After any supervisor reset, the core is held for three machine cycles of twelve divided ticks each. The block then issues a one-cycle restart strobe.

All pins are plain control and status levels or strobes. There is no streaming data path, so no valid/ready handshake exists at the edge.

Top module: `pmc_clock_ctrl`

## Requirements
- R1: After power-on reset or any accepted supervisor reset, the block holds the core. `core_hold` is 1 and `core_ce` is 0 for 36 divided ticks (3 machine cycles of 12 ticks). In the cycle after the 36th tick, `core_hold` drops and `restart_stb` is 1 for exactly one cycle.
- R2: After power-on reset the division is /1: once running, `core_ce` is 1 on every oscillator cycle.
- R3: `psel` encodes the division as 000=/1, 001=/2, 010=/4, 011=/8, 100=/16, 101=/32, 110=/1024, 111=/2048. `core_ce` is a one-cycle pulse once per divided period.
- R4: A new `psel` value is taken only at the end of the current divided period. The period in progress always completes at its old length.
- R5: In idle, `core_ce` and `wdt_ce` are 0 and `per_ce` stays 1.
- R6: An `irq_any` while idle returns the block to run. `idle_clr` is then 1 for exactly one cycle.
- R7: In power-down, `per_ce`, `core_ce` and `wdt_ce` are 0, and the divider is frozen. Neither `per_clk` nor `core_clk` pulses.
- R8: `irq_any` has no effect in power-down.
- R9: `wdt_ce` equals `core_ce` at all times, so the watchdog is frozen in idle and power-down. `rst_wdt` has no effect in either mode.
- R10: `rst_ext`, `rst_lvd` or `rst_dbg` ends power-down and starts the R1 restart sequence.
- R11: If `pd_set` and `idle_set` arrive together, power-down is entered.
- R12: `rst_wdt` in run starts the R1 restart sequence.
- R13: A supervisor reset while idle gives a one-cycle `idle_clr` as well as the R1 restart sequence.
- R14: Each gated clock pulses high in exactly the oscillator cycles that follow a cycle in which its enable was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| idle_set | input | 1 | One-cycle strobe requesting idle |
| pd_set | input | 1 | One-cycle strobe requesting power-down |
| irq_any | input | 1 | Any enabled interrupt pending |
| rst_ext | input | 1 | External reset request |
| rst_lvd | input | 1 | Low-voltage detect reset request |
| rst_dbg | input | 1 | Debug reset command |
| rst_wdt | input | 1 | Watchdog reset request |
| psel | input | 3 | Core prescaler selection |
| core_clk | output | 1 | Gated core clock |
| per_clk | output | 1 | Gated peripheral clock |
| core_ce | output | 1 | Divided core tick enable |
| per_ce | output | 1 | Peripheral clock enable |
| wdt_ce | output | 1 | Watchdog tick enable |
| core_hold | output | 1 | Core held during restart |
| idle_clr | output | 1 | Hardware clear of the idle bit |
| restart_stb | output | 1 | One-cycle core restart strobe |

## Verification
The assertions check the following on every cycle:
- No core tick while the core is held or the peripherals are off.
- Power-down is never left except through a non-watchdog reset.
- An interrupt never wakes power-down.
- The strobes last one cycle.
- The restart strobe follows a hold.

Only the scenarios can show the rest:
- The exact 36-tick restart length.
- The period of every prescaler code.
- That a mid-period `psel` change waits for the boundary.
- The pulse counts of the gated clocks against their enables.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int PSEL_W = 3;
  localparam int DIV_W  = 12;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_PDOWN = 2'd2,
    ST_HOLD  = 2'd3
  } pmode_t;

  function automatic logic [DIV_W-1:0] ratio_of(input logic [PSEL_W-1:0] sel);
    logic [3:0] sh;
    case (sel)
      3'd6:    sh = 4'd10;
      3'd7:    sh = 4'd11;
      default: sh = {1'b0, sel};
    endcase
    return DIV_W'(1) << sh;
  endfunction
endpackage

// File: rtl/pmc_prescaler.sv
module pmc_prescaler
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] ratio_q;

  assign tick = run && (cnt_q == ratio_q - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= DIV_W'(1);
    end else if (tick) begin
      cnt_q   <= '0;
      ratio_q <= ratio_of(psel);
    end else if (run) begin
      cnt_q   <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int TICKS_PER_MC = 12,
  parameter int RESTART_MC   = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   idle_set,
  input  logic   pd_set,
  input  logic   irq_any,
  input  logic   sup_hard,
  input  logic   sup_wdt,
  output pmode_t mode,
  output logic   idle_clr,
  output logic   restart_stb
);
  localparam int HOLD_TICKS = TICKS_PER_MC * RESTART_MC;
  localparam int RC_W       = $clog2(HOLD_TICKS + 1);
  localparam logic [RC_W-1:0] RC_LOAD = RC_W'(HOLD_TICKS - 1);

  pmode_t          mode_q;
  logic [RC_W-1:0] rc_q;
  logic            sup;

  assign mode = mode_q;
  assign sup  = sup_hard || (sup_wdt && mode_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= ST_HOLD;
      rc_q        <= RC_LOAD;
      idle_clr    <= 1'b0;
      restart_stb <= 1'b0;
    end else begin
      idle_clr    <= 1'b0;
      restart_stb <= 1'b0;
      if (sup) begin
        mode_q   <= ST_HOLD;
        rc_q     <= RC_LOAD;
        idle_clr <= (mode_q == ST_IDLE);
      end else begin
        case (mode_q)
          ST_HOLD: if (tick) begin
            if (rc_q == '0) begin
              mode_q      <= ST_RUN;
              restart_stb <= 1'b1;
            end else begin
              rc_q <= rc_q - RC_W'(1);
            end
          end
          ST_RUN: begin
            if (pd_set)        mode_q <= ST_PDOWN;
            else if (idle_set) mode_q <= ST_IDLE;
          end
          ST_IDLE: if (irq_any) begin
            mode_q   <= ST_RUN;
            idle_clr <= 1'b1;
          end
          default: mode_q <= mode_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic gclk
);
  logic en_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign gclk = clk & en_q;
endmodule

// File: rtl/pmc_clock_ctrl.sv
module pmc_clock_ctrl
  import pmc_pkg::*;
#(
  parameter int TICKS_PER_MC = 12,
  parameter int RESTART_MC   = 3
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              idle_set,
  input  logic              pd_set,
  input  logic              irq_any,
  input  logic              rst_ext,
  input  logic              rst_lvd,
  input  logic              rst_dbg,
  input  logic              rst_wdt,
  input  logic [PSEL_W-1:0] psel,
  output logic              core_clk,
  output logic              per_clk,
  output logic              core_ce,
  output logic              per_ce,
  output logic              wdt_ce,
  output logic              core_hold,
  output logic              idle_clr,
  output logic              restart_stb
);
  localparam int N_GATES = 2;

  pmode_t mode;
  logic   tick;
  logic   div_run;
  logic [N_GATES-1:0] gate_en;
  logic [N_GATES-1:0] gate_clk;

  assign div_run = (mode != ST_PDOWN);

  pmc_prescaler u_presc (
    .clk  (clk_osc),
    .rst_n(rst_n),
    .run  (div_run),
    .psel (psel),
    .tick (tick)
  );

  pmc_mode_fsm #(
    .TICKS_PER_MC(TICKS_PER_MC),
    .RESTART_MC  (RESTART_MC)
  ) u_fsm (
    .clk        (clk_osc),
    .rst_n      (rst_n),
    .tick       (tick),
    .idle_set   (idle_set),
    .pd_set     (pd_set),
    .irq_any    (irq_any),
    .sup_hard   (rst_ext | rst_lvd | rst_dbg),
    .sup_wdt    (rst_wdt),
    .mode       (mode),
    .idle_clr   (idle_clr),
    .restart_stb(restart_stb)
  );

  assign core_ce   = tick && (mode == ST_RUN);
  assign wdt_ce    = core_ce;
  assign per_ce    = (mode != ST_PDOWN);
  assign core_hold = (mode == ST_HOLD);

  assign gate_en = {per_ce, core_ce};

  for (genvar g = 0; g < N_GATES; g++) begin : g_gate
    pmc_clk_gate u_gate (
      .clk  (clk_osc),
      .rst_n(rst_n),
      .en   (gate_en[g]),
      .gclk (gate_clk[g])
    );
  end

  assign core_clk = gate_clk[0];
  assign per_clk  = gate_clk[1];
endmodule

// File: rtl/pmc_clock_ctrl_chk.sv
module pmc_clock_ctrl_chk (
  input logic       clk_osc,
  input logic       rst_n,
  input logic       idle_set,
  input logic       pd_set,
  input logic       irq_any,
  input logic       rst_ext,
  input logic       rst_lvd,
  input logic       rst_dbg,
  input logic       rst_wdt,
  input logic [2:0] psel,
  input logic       core_clk,
  input logic       per_clk,
  input logic       core_ce,
  input logic       per_ce,
  input logic       wdt_ce,
  input logic       core_hold,
  input logic       idle_clr,
  input logic       restart_stb
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk_osc) disable iff (!rst_n)
    core_hold |-> !core_ce); // R1
  AST_STB_AFTER_HOLD: assert property (@(posedge clk_osc) disable iff (!rst_n)
    restart_stb |-> $past(core_hold) && !core_hold); // R1
  AST_STB_SINGLE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    restart_stb |=> !restart_stb); // R1
  AST_IDLE_CLR_SINGLE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    idle_clr |=> !idle_clr); // R6
  AST_PD_NO_CORE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !per_ce |-> !core_ce && !wdt_ce); // R7
  AST_PD_IRQ_NO_WAKE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (!per_ce && !rst_ext && !rst_lvd && !rst_dbg) |=> !per_ce); // R8
  AST_PD_EXIT_BY_RESET: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $rose(per_ce) |-> core_hold); // R10
endmodule

bind pmc_clock_ctrl pmc_clock_ctrl_chk u_chk (.*);

// File: tb/tb_pmc_clock_ctrl.sv
module tb_pmc_clock_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_set = 0, pd_set = 0, irq_any = 0;
  logic rst_ext = 0, rst_lvd = 0, rst_dbg = 0, rst_wdt = 0;
  logic [2:0] psel = 3'd0;
  logic core_clk, per_clk, core_ce, per_ce, wdt_ce, core_hold, idle_clr, restart_stb;

  always #(CLK_P/2) clk = ~clk;

  pmc_clock_ctrl dut (
    .clk_osc(clk), .rst_n(rst_n), .idle_set(idle_set), .pd_set(pd_set),
    .irq_any(irq_any), .rst_ext(rst_ext), .rst_lvd(rst_lvd), .rst_dbg(rst_dbg),
    .rst_wdt(rst_wdt), .psel(psel), .core_clk(core_clk), .per_clk(per_clk),
    .core_ce(core_ce), .per_ce(per_ce), .wdt_ce(wdt_ce), .core_hold(core_hold),
    .idle_clr(idle_clr), .restart_stb(restart_stb)
  );

  typedef struct {
    logic cce, pce, hold, iclr, stb;
    string req;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  string cur_req = "R1";

  // reference model: 0 run, 1 idle, 2 power-down, 3 hold
  int m_st = 3, m_div = 0, m_rat = 1, m_rc = 35;

  function automatic int div_of(input logic [2:0] s);
    if (s == 3'd6) return 1024;
    if (s == 3'd7) return 2048;
    return 1 << s;
  endfunction

  task automatic cyc();
    exp_t e;
    bit tk, sup;
    int prev;
    tk  = (m_st != 2) && (m_div == m_rat - 1);
    sup = rst_ext || rst_lvd || rst_dbg || (rst_wdt && m_st == 0);
    prev = m_st;
    e.iclr = 0; e.stb = 0;
    if (sup) begin
      m_st = 3; m_rc = 35; e.iclr = (prev == 1);
    end else if (prev == 3) begin
      if (tk) begin
        if (m_rc == 0) begin m_st = 0; e.stb = 1; end
        else m_rc--;
      end
    end else if (prev == 0) begin
      if (pd_set) m_st = 2;
      else if (idle_set) m_st = 1;
    end else if (prev == 1 && irq_any) begin
      m_st = 0; e.iclr = 1;
    end
    if (tk) begin m_div = 0; m_rat = div_of(psel); end
    else if (prev != 2) m_div++;
    e.cce  = (m_st == 0) && (m_div == m_rat - 1);
    e.pce  = (m_st != 2);
    e.hold = (m_st == 3);
    e.req  = cur_req;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor
  int n_ce = 0, n_core_clk = 0, n_per_clk = 0;
  always @(posedge core_clk) n_core_clk++;
  always @(posedge per_clk)  n_per_clk++;

  always @(posedge clk) begin
    #(CLK_P/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (core_ce) n_ce++;
      check({e.req, " core_ce"}, core_ce, e.cce);
      check({e.req, " per_ce"}, per_ce, e.pce);
      check({e.req, " R9 wdt_ce"}, wdt_ce, e.cce);
      check({e.req, " core_hold"}, core_hold, e.hold);
      check({e.req, " idle_clr"}, idle_clr, e.iclr);
      check({e.req, " restart_stb"}, restart_stb, e.stb);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int pc0;
  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset hold", core_hold, 1);
    check("R1 reset core_ce", core_ce, 0);
    rst_n = 1'b1;
    cur_req = "R1"; run(40);
    cur_req = "R2"; run(10);
    cur_req = "R3"; psel = 3'd2; run(21);
    cur_req = "R4"; run(2); psel = 3'd3; run(40);
    cur_req = "R5"; idle_set = 1; cyc(); idle_set = 0; run(20);
    check("R14 core_clk pulses", n_core_clk, n_ce);
    cur_req = "R6"; irq_any = 1; cyc(); irq_any = 0; run(20);
    cur_req = "R7"; pd_set = 1; cyc(); pd_set = 0; run(3);
    pc0 = n_per_clk; run(10);
    cur_req = "R8"; irq_any = 1; cyc(); irq_any = 0; run(10);
    cur_req = "R9"; rst_wdt = 1; cyc(); rst_wdt = 0; run(10);
    check("R7 per_clk in power-down", n_per_clk - pc0, 0);
    cur_req = "R10"; rst_lvd = 1; cyc(); rst_lvd = 0; run(300);
    cur_req = "R11"; pd_set = 1; idle_set = 1; cyc(); pd_set = 0; idle_set = 0; run(10);
    cur_req = "R10"; rst_dbg = 1; cyc(); rst_dbg = 0; run(300);
    cur_req = "R13"; idle_set = 1; cyc(); idle_set = 0; run(5);
    cur_req = "R9"; rst_wdt = 1; cyc(); rst_wdt = 0; run(5);
    cur_req = "R13"; rst_ext = 1; cyc(); rst_ext = 0; run(300);
    cur_req = "R12"; rst_wdt = 1; cyc(); rst_wdt = 0; run(300);
    cur_req = "R3"; psel = 3'd4; run(40); psel = 3'd5; run(80);
    psel = 3'd6; run(2200); psel = 3'd7; run(4200);
    psel = 3'd1; run(2100);
    cur_req = "R14"; idle_set = 1; cyc(); idle_set = 0; run(5);
    check("R14 core_clk total", n_core_clk, n_ce);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule